// File: doc/BRIEF.md
# Quadrature Position Counter with Index Reset

This block turns two quadrature channels, A and B, into a position count in a four-edges-per-cycle scheme. A third input, the index marker, can put the count back to a known value once per revolution. The inputs must already be synchronised to the block clock. Every input is sampled on the rising edge, and every output is a register that shows the result of that edge.

When index reset is enabled, the reset value follows the direction of motion. Forward motion loads zero and reverse motion loads the configured maximum. The first index event after a flag clear sets a sticky flag, captures the direction of that step, and latches the exact A/B transition on which it happened. Later index resets fire only when the encoder crosses that same transition, in either direction. Each index pulse allows at most one reset, so a reversal while the index is still high leaves the count moving in normal single steps. A transition in which A and B change together counts as a phase error: the count holds and a sticky flag is raised.

Top module: `qdec_poscnt`

## Requirements
- R1: The forward phase order of {A,B} is 00, 10, 11, 01, then back to 00. A legal step forward adds one to the count and a legal step backward subtracts one, with the result visible after the sampling edge. `dir_fwd` reads 1 after a forward step and 0 after a reverse step, and holds its value while no legal step occurs.
- R2: Counting up from `pos_max` gives 0, and counting down from 0 gives `pos_max`.
- R3: If A and B both change in one sample, the count does not change and `phase_err` goes to 1. `phase_err` stays at 1 until it is cleared.
- R4: With `idx_reset_en`=1 and no first event recorded, the first legal step while `idx_in` is high is the first index event. On that edge the count loads 0 if the step is forward and `pos_max` if the step is reverse.
- R5: The first index event sets `first_idx_seen`, sets `first_idx_dir` (1 = forward) and latches its A/B transition. All three are kept until `flag_clr`.
- R6: After the first event, a step across the latched transition while `idx_in` is high loads the count. A forward crossing loads 0 and a reverse crossing loads `pos_max`. Any other transition counts normally.
- R7: Each high pulse of `idx_in` allows at most one load. Loads are allowed again only after `idx_in` has been sampled low. A reversal while the index is still high gives normal ±1 steps.
- R8: With `idx_reset_en`=0, the count is never loaded by the index. The first-event status is still recorded.
- R9: `flag_clr` clears `first_idx_seen`, `first_idx_dir` and `phase_err`. If an event that sets one of these flags occurs in the same cycle, the set takes effect.
- R10: After reset the count is 0, `dir_fwd` is 1, all flags are 0, and the previous phase is taken as {A,B}=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_a | input | 1 | Quadrature channel A, synchronised |
| chan_b | input | 1 | Quadrature channel B, synchronised |
| idx_in | input | 1 | Index marker, synchronised, active high |
| idx_reset_en | input | 1 | Enables loading of the count by the index |
| pos_max | input | POS_W | Highest count value, used for wrap and reverse loads |
| flag_clr | input | 1 | Clears the sticky status flags |
| pos_cnt | output | POS_W | Position count |
| dir_fwd | output | 1 | Direction of the last legal step, 1 = forward |
| first_idx_seen | output | 1 | Sticky flag: first index event recorded |
| first_idx_dir | output | 1 | Direction captured at the first index event |
| phase_err | output | 1 | Sticky flag: illegal A/B transition seen |

## Verification
Most internal faults show up at the ports one clock after the offending sample. A wrong latched transition shows only at the next index pulse, when the count loads at the wrong edge or not at all. A missing disarm shows up as a second load when the encoder reverses across the marker during a single pulse. A wrong step classification shows up at once as a count off by one, or as a spurious `phase_err`.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  // Position of an {A,B} pair along the forward cycle 00,10,11,01
  function automatic logic [1:0] phase_rank(input logic [1:0] ab);
    logic [1:0] r;
    case (ab)
      2'b00:   r = 2'd0;
      2'b10:   r = 2'd1;
      2'b11:   r = 2'd2;
      default: r = 2'd3;
    endcase
    return r;
  endfunction

  function automatic step_e classify(input logic [1:0] prev_ab,
                                     input logic [1:0] cur_ab);
    logic [1:0] rp;
    logic [1:0] rc;
    logic [1:0] rp_next;
    logic [1:0] rc_next;
    step_e      s;
    rp      = phase_rank(prev_ab);
    rc      = phase_rank(cur_ab);
    rp_next = rp + 2'd1;
    rc_next = rc + 2'd1;
    if (prev_ab == cur_ab)  s = STEP_NONE;
    else if (rc == rp_next) s = STEP_UP;
    else if (rp == rc_next) s = STEP_DOWN;
    else                    s = STEP_BAD;
    return s;
  endfunction

endpackage

// File: rtl/qdec_phase_track.sv
module qdec_phase_track
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_a,
  input  logic       chan_b,
  output logic [1:0] prev_ab,
  output logic [1:0] cur_ab,
  output step_e      step
);

  assign cur_ab = {chan_a, chan_b};
  assign step   = classify(prev_ab, cur_ab);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_ab <= 2'b00;
    else        prev_ab <= cur_ab;
  end

endmodule

// File: rtl/qdec_index_ctl.sv
module qdec_index_ctl
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_in,
  input  logic       mode_en,
  input  logic       flag_clr,
  input  step_e      step,
  input  logic [1:0] prev_ab,
  input  logic [1:0] cur_ab,
  output logic       load_zero,
  output logic       load_max,
  output logic       first_seen,
  output logic       first_dir
);

  logic       armed;
  logic [1:0] mark_from;
  logic [1:0] mark_to;
  logic       legal;
  logic       fwd_hit;
  logic       rev_hit;
  logic       first_evt;
  logic       later_evt;
  logic       any_evt;

  assign legal     = (step == STEP_UP) || (step == STEP_DOWN);
  assign fwd_hit   = (step == STEP_UP)   && (prev_ab == mark_from) && (cur_ab == mark_to);
  assign rev_hit   = (step == STEP_DOWN) && (prev_ab == mark_to)   && (cur_ab == mark_from);
  assign first_evt = idx_in && armed && !first_seen && legal;
  assign later_evt = idx_in && armed && first_seen && (fwd_hit || rev_hit);
  assign any_evt   = first_evt || later_evt;

  assign load_zero = mode_en && any_evt && (step == STEP_UP);
  assign load_max  = mode_en && any_evt && (step == STEP_DOWN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed <= 1'b1;
    else if (!idx_in)  armed <= 1'b1;
    else if (any_evt)  armed <= 1'b0;
  end

  // The transition is stored in its forward orientation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_seen <= 1'b0;
      first_dir  <= 1'b0;
      mark_from  <= 2'b00;
      mark_to    <= 2'b00;
    end else if (first_evt) begin
      first_seen <= 1'b1;
      first_dir  <= (step == STEP_UP);
      mark_from  <= (step == STEP_UP) ? prev_ab : cur_ab;
      mark_to    <= (step == STEP_UP) ? cur_ab  : prev_ab;
    end else if (flag_clr) begin
      first_seen <= 1'b0;
      first_dir  <= 1'b0;
    end
  end

endmodule

// File: rtl/qdec_pos_counter.sv
module qdec_pos_counter
  import qdec_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            step,
  input  logic             load_zero,
  input  logic             load_max,
  input  logic [POS_W-1:0] pos_max,
  output logic [POS_W-1:0] pos_cnt
);

  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  function automatic logic [POS_W-1:0] inc_wrap(input logic [POS_W-1:0] v,
                                                input logic [POS_W-1:0] top);
    return (v == top) ? '0 : v + ONE;
  endfunction

  function automatic logic [POS_W-1:0] dec_wrap(input logic [POS_W-1:0] v,
                                                input logic [POS_W-1:0] top);
    return (v == '0) ? top : v - ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pos_cnt <= '0;
    else if (load_zero) pos_cnt <= '0;
    else if (load_max)  pos_cnt <= pos_max;
    else begin
      case (step)
        STEP_UP:   pos_cnt <= inc_wrap(pos_cnt, pos_max);
        STEP_DOWN: pos_cnt <= dec_wrap(pos_cnt, pos_max);
        default:   pos_cnt <= pos_cnt;
      endcase
    end
  end

endmodule

// File: rtl/qdec_poscnt.sv
module qdec_poscnt
  import qdec_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_a,
  input  logic             chan_b,
  input  logic             idx_in,
  input  logic             idx_reset_en,
  input  logic [POS_W-1:0] pos_max,
  input  logic             flag_clr,
  output logic [POS_W-1:0] pos_cnt,
  output logic             dir_fwd,
  output logic             first_idx_seen,
  output logic             first_idx_dir,
  output logic             phase_err
);

  logic [1:0] prev_ab;
  logic [1:0] cur_ab;
  step_e      step;
  logic       step_up;
  logic       step_dn;
  logic       step_bad;
  logic       load_zero;
  logic       load_max;

  qdec_phase_track u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .chan_a  (chan_a),
    .chan_b  (chan_b),
    .prev_ab (prev_ab),
    .cur_ab  (cur_ab),
    .step    (step)
  );

  assign step_up  = (step == STEP_UP);
  assign step_dn  = (step == STEP_DOWN);
  assign step_bad = (step == STEP_BAD);

  qdec_index_ctl u_index (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_in     (idx_in),
    .mode_en    (idx_reset_en),
    .flag_clr   (flag_clr),
    .step       (step),
    .prev_ab    (prev_ab),
    .cur_ab     (cur_ab),
    .load_zero  (load_zero),
    .load_max   (load_max),
    .first_seen (first_idx_seen),
    .first_dir  (first_idx_dir)
  );

  qdec_pos_counter #(.POS_W(POS_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .load_zero (load_zero),
    .load_max  (load_max),
    .pos_max   (pos_max),
    .pos_cnt   (pos_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dir_fwd <= 1'b1;
    else if (step_up) dir_fwd <= 1'b1;
    else if (step_dn) dir_fwd <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_err <= 1'b0;
    else if (step_bad) phase_err <= 1'b1;
    else if (flag_clr) phase_err <= 1'b0;
  end

endmodule

// File: rtl/qdec_poscnt_chk.sv
module qdec_poscnt_chk #(
  parameter int POS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flag_clr,
  input logic [POS_W-1:0] pos_max,
  input logic [POS_W-1:0] pos_cnt,
  input logic             dir_fwd,
  input logic             phase_err,
  input logic             first_idx_seen,
  input logic             step_up,
  input logic             step_dn,
  input logic             step_bad,
  input logic             load_zero,
  input logic             load_max
);

  AST_UP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !load_zero) |=> pos_cnt == (($past(pos_cnt) == $past(pos_max)) ? '0 : $past(pos_cnt) + 1'b1)); // R2

  AST_DOWN_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !load_max) |=> pos_cnt == (($past(pos_cnt) == '0) ? $past(pos_max) : $past(pos_cnt) - 1'b1)); // R1

  AST_DIR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |=> dir_fwd); // R1

  AST_BAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    step_bad |=> ($stable(pos_cnt) && phase_err)); // R3

  AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_zero |=> pos_cnt == '0); // R4

  AST_MAX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_max |=> pos_cnt == $past(pos_max)); // R6

  AST_ONE_LOAD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_zero, load_max})); // R6

  AST_SINGLE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_zero || load_max) |=> !(load_zero || load_max)); // R7

  AST_FIRST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (first_idx_seen && !flag_clr) |=> first_idx_seen); // R5

endmodule

bind qdec_poscnt qdec_poscnt_chk #(.POS_W(POS_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .flag_clr       (flag_clr),
  .pos_max        (pos_max),
  .pos_cnt        (pos_cnt),
  .dir_fwd        (dir_fwd),
  .phase_err      (phase_err),
  .first_idx_seen (first_idx_seen),
  .step_up        (step_up),
  .step_dn        (step_dn),
  .step_bad       (step_bad),
  .load_zero      (load_zero),
  .load_max       (load_max)
);

// File: tb/qdec_poscnt_test.sv
module qdec_poscnt_test;

  localparam int W = 16;
  localparam int NVEC = 37;

  // {a,b,idx,clr} [15:12], expected count [11:4], {dir,seen,fdir,err} [3:0]
  localparam logic [15:0] VEC [NVEC] = '{
    16'h8018, 16'hC028, 16'h4038, 16'h0048, 16'h2048, 16'hA00E, 16'hE01E,
    16'hA006, 16'h2096, 16'hA00E, 16'hC01E, 16'h402E, 16'h003E, 16'h804E,
    16'hC05E, 16'hE05E, 16'hA046, 16'h2096, 16'hA00E, 16'h0096, 16'hC097,
    16'hD090, 16'h4008, 16'h6008, 16'hE094, 16'h400C, 16'hC094, 16'h0095,
    16'h800D, 16'hC01D, 16'h402D, 16'hC015, 16'hE015, 16'h600D, 16'h201D,
    16'h6005, 16'hE095
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         chan_a = 1'b0;
  logic         chan_b = 1'b0;
  logic         idx_in = 1'b0;
  logic         idx_reset_en = 1'b1;
  logic [W-1:0] pos_max = W'(9);
  logic         flag_clr = 1'b0;
  logic [W-1:0] pos_cnt;
  logic         dir_fwd;
  logic         first_idx_seen;
  logic         first_idx_dir;
  logic         phase_err;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  qdec_poscnt #(.POS_W(W)) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .chan_a         (chan_a),
    .chan_b         (chan_b),
    .idx_in         (idx_in),
    .idx_reset_en   (idx_reset_en),
    .pos_max        (pos_max),
    .flag_clr       (flag_clr),
    .pos_cnt        (pos_cnt),
    .dir_fwd        (dir_fwd),
    .first_idx_seen (first_idx_seen),
    .first_idx_dir  (first_idx_dir),
    .phase_err      (phase_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge
  task automatic step_in(input logic a, input logic b, input logic idx, input logic clr);
    chan_a   = a;
    chan_b   = b;
    idx_in   = idx;
    flag_clr = clr;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R10 count", 32'(pos_cnt), 32'd0);
    check("R10 dir", 32'(dir_fwd), 32'd1);
    check("R10 flags", 32'({first_idx_seen, first_idx_dir, phase_err}), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      step_in(VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12]);
      check($sformatf("R1 R2 R4 R6 R7 count vec %0d", i), 32'(pos_cnt), 32'(VEC[i][11:4]));
      check($sformatf("R1 dir vec %0d", i), 32'(dir_fwd), 32'(VEC[i][3]));
      check($sformatf("R3 R5 R9 flags vec %0d", i),
            32'({first_idx_seen, first_idx_dir, phase_err}), 32'(VEC[i][2:0]));
    end

    // Reset again: state must return to the reset values
    step_in(1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 count after reset", 32'(pos_cnt), 32'd0);
    check("R10 flags after reset",
          32'({dir_fwd, first_idx_seen, first_idx_dir, phase_err}), 32'h8);
    rst_n = 1'b1;

    // Index loads disabled: the index event is recorded, the count is not loaded
    idx_reset_en = 1'b0;
    step_in(1'b0, 1'b0, 1'b1, 1'b0);
    step_in(1'b1, 1'b0, 1'b1, 1'b0);
    check("R8 no load with mode off", 32'(pos_cnt), 32'd1);
    check("R8 status still recorded", 32'({first_idx_seen, first_idx_dir}), 32'h3);
    step_in(1'b1, 1'b1, 1'b1, 1'b0);
    check("R8 counts on", 32'(pos_cnt), 32'd2);

    // Clear in the same cycle as an illegal transition: the error set wins
    step_in(1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 set beats clear", 32'(phase_err), 32'd1);
    check("R9 first flags cleared", 32'({first_idx_seen, first_idx_dir}), 32'd0);
    check("R3 count held on illegal", 32'(pos_cnt), 32'd2);

    // Reverse from 0 wraps to the maximum with index loads off
    step_in(1'b0, 1'b1, 1'b0, 1'b0);
    step_in(1'b1, 1'b1, 1'b0, 1'b0);
    step_in(1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 down wrap", 32'(pos_cnt), 32'd9);
    check("R1 reverse dir", 32'(dir_fwd), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule